// File: doc/BRIEF.md
# Decode-Stage Issue Interlock

This unit decides, every cycle, whether the instruction sitting in decode of a five-stage in-order pipeline may move on to execute. The pipeline has a main path (fetch, decode, execute, memory, writeback) and a side path for multiply and divide. The side path runs for `SIDE_LAT` execute cycles and then enters writeback directly, skipping memory. All interlocking happens in decode. Execute, memory and writeback never stop. When decode holds, the unit freezes fetch and the fetch/decode register, and it sends an empty slot into execute.

The unit keeps its own record of what is in flight. A short shift register holds one entry for each instruction that left decode in each of the last `SIDE_LAT` cycles. Each entry carries the destination register, whether the instruction writes it, and its operation class. An entry's position in the shift register is its age, and its age tells when its result can be used. The unit checks the decoding instruction's sources against these entries, taking into account which bypass paths are enabled. It also checks two shared resources: the single writeback slot and the one unpipelined divider.

Top module: `hzd_decode_hazard`

## Requirements
- R1: After reset nothing is counted as in flight, so the first valid instruction in decode, even a divide, leaves decode without stalling.
- R2: `dec_stall`, `fetch_hold` and `ex_bubble` are always equal. All three are low in any cycle where `dec_valid` is low, even when the decode fields name a pending register.
- R3: With both bypasses off, a consumer of a main-path result (class 0 = ALU or 1 = memory-result) leaves decode in the producer's writeback cycle. Back to back, this costs 2 stall cycles. With one unrelated instruction between them, it costs 1. The dependence can come through either source field.
- R4: With only the writeback-to-execute bypass on (`byp_wx_en`=1), a consumer directly behind an ALU producer stalls for 1 cycle.
- R5: With the memory-to-execute bypass also on (`byp_mx_en`=1), a consumer directly behind an ALU producer does not stall. A consumer directly behind a memory-result producer still stalls for 1 cycle.
- R6: A consumer directly behind a side-path producer (class 2 = multiply, 3 = divide) stalls for `SIDE_LAT`-1 cycles (3) when `byp_wx_en`=1, and for `SIDE_LAT` cycles (4) when it is 0.
- R7: Register 0 never counts as a dependence. A source whose use flag is low never counts as a dependence.
- R8: A main-path instruction whose writeback would land in the same cycle as an older side-path instruction's writeback stalls. With a side-path instruction followed by two independent main-path instructions, the second one stalls for 1 cycle.
- R9: A divide stalls until the previous divide has used the divider for all `SIDE_LAT` cycles. Directly behind another divide, it stalls 3 cycles. With one instruction between them, it stalls 2 cycles. A multiply never waits for the divider, and neither does a second multiply.
- R10: A stalled instruction remains in decode until its last hazard clears. It leaves decode in exactly that cycle, and from then on it counts as a producer for later instructions.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dec_valid | input | 1 | Decode holds a real instruction |
| dec_kind | input | 2 | Class: 0 ALU, 1 memory-result, 2 multiply, 3 divide |
| dec_rs1 | input | REG_W (5) | First source register number |
| dec_rs1_use | input | 1 | First source is read |
| dec_rs2 | input | REG_W (5) | Second source register number |
| dec_rs2_use | input | 1 | Second source is read |
| dec_rd | input | REG_W (5) | Destination register number |
| dec_rd_we | input | 1 | Instruction writes its destination |
| byp_mx_en | input | 1 | Memory-stage result may feed execute |
| byp_wx_en | input | 1 | Writeback-stage result may feed execute |
| dec_stall | output | 1 | Decode holds its instruction this cycle |
| fetch_hold | output | 1 | Program counter write disable and fetch/decode register hold |
| ex_bubble | output | 1 | Execute receives an empty slot next cycle |

## Verification
All three outputs are combinational. They answer in the same cycle that the decode fields are presented, and the shift-register record changes one clock edge after an instruction leaves decode. For each instruction the driver queues the number of stall cycles it should accumulate. The monitor samples on the falling edge, after the inputs have settled. It counts consecutive stall cycles and compares the count with the queued value in the cycle where the instruction leaves decode. That cycle is the earliest one the requirements allow, so a stall that ends one cycle early or one cycle late shows up as a miscompare.

// File: rtl/hzd_pkg.sv
// Shared types and timing helpers for the decode hazard unit.
// Assumes a main path whose writeback is MAIN_WB_AGE cycles after decode.
package hzd_pkg;

    typedef enum logic [1:0] {
        OP_ALU = 2'd0,
        OP_MEM = 2'd1,
        OP_MUL = 2'd2,
        OP_DIV = 2'd3
    } op_kind_e;

    // Cycles from leaving decode to writeback on the main path.
    localparam int unsigned MAIN_WB_AGE = 3;

    // True for classes that use the long-latency side path.
    function automatic logic is_side(input op_kind_e k);
        return (k == OP_MUL) || (k == OP_DIV);
    endfunction

    // Smallest age (cycles since the producer left decode) at which a
    // consumer in decode may leave decode and still receive the value.
    function automatic int unsigned ready_age(input op_kind_e k,
                                              input logic mx,
                                              input logic wx,
                                              input int unsigned side_lat);
        int unsigned r;
        case (k)
            OP_ALU:  r = mx ? 1 : (wx ? MAIN_WB_AGE - 1 : MAIN_WB_AGE);
            OP_MEM:  r = wx ? MAIN_WB_AGE - 1 : MAIN_WB_AGE;
            default: r = wx ? side_lat : side_lat + 1;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/hzd_inflight_track.sv
// Shift-register record of instructions that recently left decode.
// Slot i holds the instruction that left decode i+1 cycles ago.
// Assumes at most one push per cycle; an empty push records a bubble.
module hzd_inflight_track
    import hzd_pkg::*;
#(
    parameter int REG_W = 5,
    parameter int DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_valid,
    input  logic             push_we,
    input  logic [REG_W-1:0] push_rd,
    input  op_kind_e         push_kind,
    output logic             slot_valid [DEPTH],
    output logic             slot_we    [DEPTH],
    output logic [REG_W-1:0] slot_rd    [DEPTH],
    output op_kind_e         slot_kind  [DEPTH]
);

    localparam int MAIN_WB_IDX = MAIN_WB_AGE - 2;

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        if (g == 0) begin : g_head
            // Capture the instruction leaving decode, or a bubble.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    slot_valid[g] <= 1'b0;
                    slot_we[g]    <= 1'b0;
                    slot_rd[g]    <= '0;
                    slot_kind[g]  <= OP_ALU;
                end else begin
                    slot_valid[g] <= push_valid;
                    slot_we[g]    <= push_valid && push_we;
                    slot_rd[g]    <= push_rd;
                    slot_kind[g]  <= push_kind;
                end
            end
        end else begin : g_body
            // Age each entry by one cycle.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    slot_valid[g] <= 1'b0;
                    slot_we[g]    <= 1'b0;
                    slot_rd[g]    <= '0;
                    slot_kind[g]  <= OP_ALU;
                end else begin
                    slot_valid[g] <= slot_valid[g-1];
                    slot_we[g]    <= slot_we[g-1];
                    slot_rd[g]    <= slot_rd[g-1];
                    slot_kind[g]  <= slot_kind[g-1];
                end
            end
        end
    end

    logic [DEPTH-1:0] div_vec;

    // Flag entries that are occupying the divider.
    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            div_vec[i] = slot_valid[i] && (slot_kind[i] == OP_DIV);
        end
    end

    // R9: the divider never holds two divides at once.
    assert_single_divider_R9: assert property (
        @(posedge clk) disable iff (!rst_n) $onehot0(div_vec)
    );

    // R8: a side result and a main result never reach writeback together.
    assert_wb_unique_R8: assert property (
        @(posedge clk) disable iff (!rst_n)
        !(slot_valid[DEPTH-1] && is_side(slot_kind[DEPTH-1]) &&
          slot_valid[MAIN_WB_IDX] && !is_side(slot_kind[MAIN_WB_IDX]))
    );

endmodule

// File: rtl/hzd_raw_check.sv
// Read-after-write dependence check of the decode sources against every
// in-flight destination, honouring which bypass paths are enabled.
// Assumes register 0 is hardwired and never produces a dependence.
module hzd_raw_check
    import hzd_pkg::*;
#(
    parameter int REG_W    = 5,
    parameter int DEPTH    = 4,
    parameter int SIDE_LAT = 4,
    parameter int NUM_SRC  = 2
) (
    input  logic             src_use    [NUM_SRC],
    input  logic [REG_W-1:0] src_reg    [NUM_SRC],
    input  logic             slot_valid [DEPTH],
    input  logic             slot_we    [DEPTH],
    input  logic [REG_W-1:0] slot_rd    [DEPTH],
    input  op_kind_e         slot_kind  [DEPTH],
    input  logic             byp_mx_en,
    input  logic             byp_wx_en,
    output logic             raw_hit
);

    logic [NUM_SRC-1:0][DEPTH-1:0] hit;

    for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
        for (genvar k = 0; k < DEPTH; k++) begin : g_age
            // One source against one in-flight entry of age k+1.
            always_comb begin
                hit[s][k] = src_use[s] && (src_reg[s] != '0) &&
                            slot_valid[k] && slot_we[k] &&
                            (slot_rd[k] == src_reg[s]) &&
                            (unsigned'(k + 1) <
                             ready_age(slot_kind[k], byp_mx_en, byp_wx_en,
                                       unsigned'(SIDE_LAT)));
            end
        end
    end

    // Any source waiting on any entry holds decode.
    assign raw_hit = |hit;

endmodule

// File: rtl/hzd_struct_check.sv
// Structural conflict check: the shared writeback slot and the single
// unpipelined divider. Multiplies are pipelined and never wait here.
// Assumes side-path instructions reach writeback SIDE_LAT+1 cycles after
// leaving decode.
module hzd_struct_check
    import hzd_pkg::*;
#(
    parameter int DEPTH    = 4,
    parameter int SIDE_LAT = 4
) (
    input  op_kind_e dec_kind,
    input  logic     slot_valid [DEPTH],
    input  op_kind_e slot_kind  [DEPTH],
    output logic     wb_clash,
    output logic     div_busy
);

    localparam int CLASH_IDX = SIDE_LAT - int'(MAIN_WB_AGE);

    if (CLASH_IDX >= 0 && CLASH_IDX < DEPTH) begin : g_clash
        // A main-path issue now would share writeback with this side entry.
        always_comb begin
            wb_clash = !is_side(dec_kind) && slot_valid[CLASH_IDX] &&
                       is_side(slot_kind[CLASH_IDX]);
        end
    end else begin : g_no_clash
        assign wb_clash = 1'b0;
    end

    // A divide waits while an older divide still occupies the divider.
    always_comb begin
        div_busy = 1'b0;
        for (int i = 0; i < DEPTH - 1; i++) begin
            if (slot_valid[i] && (slot_kind[i] == OP_DIV) &&
                (dec_kind == OP_DIV)) begin
                div_busy = 1'b1;
            end
        end
    end

endmodule

// File: rtl/hzd_decode_hazard.sv
// Decode-stage issue interlock for a five-stage in-order pipeline with a
// SIDE_LAT-cycle multiply/divide side path. Holds decode and fetch, and
// sends a bubble to execute, on data or structural hazards.
// Assumes execute, memory and writeback never stall.
module hzd_decode_hazard
    import hzd_pkg::*;
#(
    parameter  int NUM_REGS = 32,
    parameter  int SIDE_LAT = 4,
    localparam int REG_W    = $clog2(NUM_REGS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             dec_valid,
    input  logic [1:0]       dec_kind,
    input  logic [REG_W-1:0] dec_rs1,
    input  logic             dec_rs1_use,
    input  logic [REG_W-1:0] dec_rs2,
    input  logic             dec_rs2_use,
    input  logic [REG_W-1:0] dec_rd,
    input  logic             dec_rd_we,
    input  logic             byp_mx_en,
    input  logic             byp_wx_en,
    output logic             dec_stall,
    output logic             fetch_hold,
    output logic             ex_bubble
);

    localparam int DEPTH   = SIDE_LAT;
    localparam int NUM_SRC = 2;

    op_kind_e         kind;
    logic             src_use    [NUM_SRC];
    logic [REG_W-1:0] src_reg    [NUM_SRC];
    logic             slot_valid [DEPTH];
    logic             slot_we    [DEPTH];
    logic [REG_W-1:0] slot_rd    [DEPTH];
    op_kind_e         slot_kind  [DEPTH];
    logic             raw_hit;
    logic             wb_clash;
    logic             div_busy;
    logic             issue;

    // Gather the decode fields into the form the checks use.
    always_comb begin
        kind       = op_kind_e'(dec_kind);
        src_use[0] = dec_rs1_use;
        src_reg[0] = dec_rs1;
        src_use[1] = dec_rs2_use;
        src_reg[1] = dec_rs2;
    end

    // Combine all hazard sources into the stall outputs.
    always_comb begin
        dec_stall  = dec_valid && (raw_hit || wb_clash || div_busy);
        fetch_hold = dec_stall;
        ex_bubble  = dec_stall;
        issue      = dec_valid && !dec_stall;
    end

    hzd_inflight_track #(
        .REG_W (REG_W),
        .DEPTH (DEPTH)
    ) u_track (
        .clk        (clk),
        .rst_n      (rst_n),
        .push_valid (issue),
        .push_we    (dec_rd_we),
        .push_rd    (dec_rd),
        .push_kind  (kind),
        .slot_valid (slot_valid),
        .slot_we    (slot_we),
        .slot_rd    (slot_rd),
        .slot_kind  (slot_kind)
    );

    hzd_raw_check #(
        .REG_W    (REG_W),
        .DEPTH    (DEPTH),
        .SIDE_LAT (SIDE_LAT),
        .NUM_SRC  (NUM_SRC)
    ) u_raw (
        .src_use    (src_use),
        .src_reg    (src_reg),
        .slot_valid (slot_valid),
        .slot_we    (slot_we),
        .slot_rd    (slot_rd),
        .slot_kind  (slot_kind),
        .byp_mx_en  (byp_mx_en),
        .byp_wx_en  (byp_wx_en),
        .raw_hit    (raw_hit)
    );

    hzd_struct_check #(
        .DEPTH    (DEPTH),
        .SIDE_LAT (SIDE_LAT)
    ) u_struct (
        .dec_kind   (kind),
        .slot_valid (slot_valid),
        .slot_kind  (slot_kind),
        .wb_clash   (wb_clash),
        .div_busy   (div_busy)
    );

    // R2: a stall only ever holds a real instruction.
    assert_stall_needs_valid_R2: assert property (
        @(posedge clk) disable iff (!rst_n) dec_stall |-> dec_valid
    );

    // R2: a stall cycle puts nothing into the in-flight record.
    assert_bubble_empty_R2: assert property (
        @(posedge clk) disable iff (!rst_n) dec_stall |=> !slot_valid[0]
    );

    // R10: an instruction that leaves decode is recorded as a producer.
    assert_issue_tracked_R10: assert property (
        @(posedge clk) disable iff (!rst_n)
        (dec_valid && !dec_stall) |=>
            (slot_valid[0] && (slot_rd[0] == $past(dec_rd)))
    );

endmodule

// File: tb/hzd_decode_hazard_tb.sv
// Scoreboard bench: the driver queues the expected stall count per
// instruction; the monitor counts stall cycles and compares at issue.
module hzd_decode_hazard_tb;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;
    localparam logic [1:0] K_ALU = 2'd0;
    localparam logic [1:0] K_MEM = 2'd1;
    localparam logic [1:0] K_MUL = 2'd2;
    localparam logic [1:0] K_DIV = 2'd3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       dec_valid = 1'b0;
    logic [1:0] dec_kind = K_ALU;
    logic [4:0] dec_rs1 = '0;
    logic       dec_rs1_use = 1'b0;
    logic [4:0] dec_rs2 = '0;
    logic       dec_rs2_use = 1'b0;
    logic [4:0] dec_rd = '0;
    logic       dec_rd_we = 1'b0;
    logic       byp_mx_en = 1'b0;
    logic       byp_wx_en = 1'b0;
    logic       dec_stall;
    logic       fetch_hold;
    logic       ex_bubble;

    int    vectors = 0;
    int    fails = 0;
    bit    done = 1'b0;
    int    exp_q[$];
    string tag_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    hzd_decode_hazard u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .dec_valid   (dec_valid),
        .dec_kind    (dec_kind),
        .dec_rs1     (dec_rs1),
        .dec_rs1_use (dec_rs1_use),
        .dec_rs2     (dec_rs2),
        .dec_rs2_use (dec_rs2_use),
        .dec_rd      (dec_rd),
        .dec_rd_we   (dec_rd_we),
        .byp_mx_en   (byp_mx_en),
        .byp_wx_en   (byp_wx_en),
        .dec_stall   (dec_stall),
        .fetch_hold  (fetch_hold),
        .ex_bubble   (ex_bubble)
    );

    // Present one instruction and hold it until it leaves decode.
    task automatic put(input logic [1:0] k, input logic [4:0] rd,
                       input logic we, input logic [4:0] s1, input logic u1,
                       input logic [4:0] s2, input logic u2,
                       input int exp_stalls, input string tag);
        bit s;
        exp_q.push_back(exp_stalls);
        tag_q.push_back(tag);
        dec_valid = 1'b1;  dec_kind = k;
        dec_rd = rd;       dec_rd_we = we;
        dec_rs1 = s1;      dec_rs1_use = u1;
        dec_rs2 = s2;      dec_rs2_use = u2;
        do begin
            @(negedge clk);
            s = (dec_stall === 1'b1);
            @(posedge clk);
            #1;
        end while (s);
    endtask

    // Leave decode empty for n cycles, keeping the current fields.
    task automatic idle(input int n);
        dec_valid = 1'b0;
        repeat (n) @(posedge clk);
        #1;
    endtask

    // Monitor: count stall cycles per instruction, compare at issue.
    initial begin
        int run = 0;
        forever begin
            @(negedge clk);
            if (rst_n && !done) begin
                vectors++;
                if (!dec_valid) begin
                    // R2: nothing asserted without a valid instruction
                    if ({dec_stall, fetch_hold, ex_bubble} !== 3'b000) begin
                        fails++;
                        $display("FAIL R2 idle outputs actual=%b%b%b expected=000",
                                 dec_stall, fetch_hold, ex_bubble);
                    end
                    run = 0;
                end else begin
                    // R2: the three outputs move together
                    if (fetch_hold !== dec_stall || ex_bubble !== dec_stall) begin
                        fails++;
                        $display("FAIL R2 outputs differ actual=%b%b%b expected all equal",
                                 dec_stall, fetch_hold, ex_bubble);
                    end
                    if (dec_stall === 1'b1) begin
                        run++;
                    end else if (exp_q.size() == 0) begin
                        fails++;
                        $display("FAIL R10 unexpected issue actual=issue expected=none");
                        run = 0;
                    end else begin
                        int    e;
                        string t;
                        e = exp_q.pop_front();
                        t = tag_q.pop_front();
                        vectors++;
                        if (run != e) begin
                            fails++;
                            $display("FAIL %s stall cycles actual=%0d expected=%0d",
                                     t, run, e);
                        end
                        run = 0;
                    end
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    // Stimulus.
    initial begin
        repeat (4) @(posedge clk);
        #1;
        rst_n = 1'b1;
        idle(2);

        // R1: empty after reset, first divide goes straight through
        put(K_DIV, 5'd5, 1, 5'd1, 1, 5'd2, 1, 0, "R1");
        idle(6);

        // R3: no bypass, adjacent consumer, then one in between via rs2
        byp_mx_en = 1'b0; byp_wx_en = 1'b0;
        put(K_ALU, 5'd3, 1, 5'd1, 1, 5'd2, 1, 0, "R3");
        put(K_ALU, 5'd4, 1, 5'd3, 1, 5'd2, 1, 2, "R3");
        idle(6);
        put(K_ALU, 5'd3, 1, 5'd1, 1, 5'd2, 1, 0, "R3");
        put(K_ALU, 5'd7, 1, 5'd8, 1, 5'd9, 1, 0, "R3");
        put(K_ALU, 5'd4, 1, 5'd1, 1, 5'd3, 1, 1, "R3");
        idle(6);
        put(K_MEM, 5'd6, 1, 5'd1, 1, 5'd2, 0, 0, "R3");
        put(K_ALU, 5'd4, 1, 5'd6, 1, 5'd2, 1, 2, "R3");
        idle(6);

        // R2: invalid decode naming a pending register does not stall
        put(K_ALU, 5'd3, 1, 5'd1, 1, 5'd2, 1, 0, "R2");
        dec_rs1 = 5'd3; dec_rs1_use = 1'b1;
        idle(6);

        // R7: register zero and unused sources are not dependences
        put(K_ALU, 5'd0, 1, 5'd1, 1, 5'd2, 1, 0, "R7");
        put(K_ALU, 5'd4, 1, 5'd0, 1, 5'd0, 1, 0, "R7");
        idle(6);
        put(K_ALU, 5'd4, 1, 5'd1, 1, 5'd2, 1, 0, "R7");
        put(K_ALU, 5'd5, 1, 5'd4, 0, 5'd4, 0, 0, "R7");
        idle(6);

        // R4: writeback bypass only
        byp_wx_en = 1'b1;
        put(K_ALU, 5'd3, 1, 5'd1, 1, 5'd2, 1, 0, "R4");
        put(K_ALU, 5'd4, 1, 5'd3, 1, 5'd2, 1, 1, "R4");
        idle(6);

        // R6: side-path producer with writeback bypass
        put(K_MUL, 5'd8, 1, 5'd1, 1, 5'd2, 1, 0, "R6");
        put(K_ALU, 5'd4, 1, 5'd8, 1, 5'd2, 1, 3, "R6");
        idle(6);

        // R5: both bypasses
        byp_mx_en = 1'b1;
        put(K_ALU, 5'd3, 1, 5'd1, 1, 5'd2, 1, 0, "R5");
        put(K_ALU, 5'd4, 1, 5'd3, 1, 5'd2, 1, 0, "R5");
        idle(6);
        put(K_MEM, 5'd3, 1, 5'd1, 1, 5'd2, 0, 0, "R5");
        put(K_ALU, 5'd4, 1, 5'd3, 1, 5'd2, 1, 1, "R5");
        idle(6);

        // R8: writeback slot clash behind a side-path instruction
        put(K_MUL, 5'd9,  1, 5'd1, 1, 5'd2, 1, 0, "R8");
        put(K_ALU, 5'd10, 1, 5'd1, 1, 5'd2, 1, 0, "R8");
        put(K_ALU, 5'd11, 1, 5'd1, 1, 5'd2, 1, 1, "R8");
        idle(6);
        put(K_DIV, 5'd9,  1, 5'd1, 1, 5'd2, 1, 0, "R8");
        put(K_ALU, 5'd10, 1, 5'd1, 1, 5'd2, 1, 0, "R8");
        put(K_MEM, 5'd11, 1, 5'd1, 1, 5'd2, 0, 1, "R8");
        idle(6);

        // R9: single unpipelined divider
        put(K_DIV, 5'd12, 1, 5'd1, 1, 5'd2, 1, 0, "R9");
        put(K_DIV, 5'd13, 1, 5'd1, 1, 5'd2, 1, 3, "R9");
        idle(6);
        put(K_DIV, 5'd12, 1, 5'd1, 1, 5'd2, 1, 0, "R9");
        put(K_MUL, 5'd13, 1, 5'd1, 1, 5'd2, 1, 0, "R9");
        put(K_MUL, 5'd14, 1, 5'd1, 1, 5'd2, 1, 0, "R9");
        idle(6);
        put(K_DIV, 5'd12, 1, 5'd1, 1, 5'd2, 1, 0, "R9");
        put(K_ALU, 5'd13, 1, 5'd1, 1, 5'd2, 1, 0, "R9");
        put(K_DIV, 5'd14, 1, 5'd1, 1, 5'd2, 1, 2, "R9");
        idle(6);

        // R6: side-path producer with no bypass
        byp_mx_en = 1'b0; byp_wx_en = 1'b0;
        put(K_MUL, 5'd8, 1, 5'd1, 1, 5'd2, 1, 0, "R6");
        put(K_ALU, 5'd4, 1, 5'd1, 1, 5'd8, 1, 4, "R6");
        idle(6);

        // R10: stalled consumer then becomes a producer itself
        put(K_ALU, 5'd3, 1, 5'd1, 1, 5'd2, 1, 0, "R10");
        put(K_ALU, 5'd4, 1, 5'd3, 1, 5'd2, 1, 2, "R10");
        put(K_ALU, 5'd5, 1, 5'd4, 1, 5'd2, 1, 2, "R10");
        idle(4);

        if (exp_q.size() != 0) begin
            fails++;
            $display("FAIL R10 pending instructions actual=%0d expected=0",
                     exp_q.size());
        end
        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule